// File: doc/BRIEF.md
# Receive Address Filter with Automatic Acknowledge Scheduling

This block watches the byte stream of a received frame for a low-rate wireless link and works through its MAC header one byte at a time. It first decodes the frame-control word. It then walks the destination and source addressing fields, whose lengths follow from the addressing-mode subfields and from the intra-PAN flag. The destination fields are compared with the node's own PAN identifier, its 16-bit short address and its 64-bit extended address. The block reports an address-match pulse once the addressing fields are complete. It reports a frame-end pulse after the last byte, and with that pulse it latches the CRC verdict supplied by the receiver.

A frame may need an acknowledgement. That is the case when the frame passed the filter, its CRC is good and it asks for one. For such a frame the block counts symbol ticks and then raises an acknowledge request that carries the frame's sequence number. The request stays up until the transmitter grants it. Configuration inputs select a promiscuous mode, two policies for the reserved frame types, and a short acknowledge turnaround.

The receive stream is framed as follows. A byte with `rx_sof` set carries the frame length in its low 7 bits. The next `length` bytes carry the frame body, and the last two of those are the check sequence. Multi-byte fields arrive least-significant byte first.

Top module: `rx_frame_filter`

## Requirements
- R1: While reset is low and just after it is released, `addr_match`, `frame_end`, `crc_valid` and `ack_req` are 0.
- R2: A length byte whose low 7 bits are zero starts no frame: it raises neither `addr_match` nor `frame_end`.
- R3: The frame-control word is body bytes 0 (low) and 1 (high), and body byte 2 is the sequence number. In the frame-control word, bits [2:0] are the type, bit 5 requests an ACK, bit 6 is intra-PAN, bits [11:10] are the destination mode and bits [15:14] are the source mode. A mode of 2'b10 means a 2-byte address and 2'b11 means an 8-byte address; any other mode means no address, and a PAN field is present only alongside an address. Take a frame with a short destination whose PAN and address equal the configured values. For it, `addr_match` pulses in the cycle after the last byte of the addressing fields (destination PAN and address, then source PAN and address), and `frame_end` pulses in the cycle after the last body byte.
- R4: A destination PAN of 0xFFFF and a short destination of 0xFFFF are accepted as broadcast. Any other mismatch gives `frame_end` only.
- R5: An extended destination matches only when all 64 bits equal the configured extended address. No broadcast value exists for it.
- R6: When both addresses are present and intra-PAN is set, the source PAN field is absent, and the addressing fields end 2 bytes earlier.
- R7: Types 3'b100 to 3'b111 are reserved. With reserved filtering off and upload on, such a frame gives `frame_end` only, whatever its addresses. With both off, it gives no event.
- R8: With reserved filtering on, a reserved-type frame is matched exactly like a data frame.
- R9: In promiscuous mode, every frame that reaches the end of its addressing fields gives `addr_match`, whatever its addresses. No ACK is ever requested in this mode.
- R10: `crc_valid` takes the value of `rx_crc_ok` presented with the last body byte, in the cycle `frame_end` pulses, and holds until the next `frame_end`.
- R11: After a matched frame with a good CRC and bit 5 set, `ack_req` rises on the 192nd `sym_tick` (12 symbols of 16 ticks) counted after `frame_end`. It carries the sequence number on `ack_seq` and holds both until `ack_grant` is seen high.
- R12: With `cfg_fast_ack` high when the delay starts, `ack_req` rises on the 32nd tick (2 symbols) instead.
- R13: No ACK is requested when the CRC is bad, when bit 5 is clear, or when the frame did not match.
- R14: A frame that ends before its addressing fields are complete gives `frame_end` only. A frame whose addressing fields end on its last byte gives `addr_match` and `frame_end` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_sof | input | 1 | With `rx_valid`: this byte is the length byte |
| rx_data | input | 8 | Received byte |
| rx_crc_ok | input | 1 | CRC verdict, read with the last body byte |
| sym_tick | input | 1 | Symbol-clock tick, 16 per symbol |
| cfg_pan_id | input | 16 | Own PAN identifier |
| cfg_short_addr | input | 16 | Own short address |
| cfg_ext_addr | input | 64 | Own extended address |
| cfg_promisc | input | 1 | Promiscuous mode |
| cfg_res_upload | input | 1 | Report reserved-type frames without filtering |
| cfg_res_filter | input | 1 | Filter reserved-type frames like data frames |
| cfg_fast_ack | input | 1 | Use the 2-symbol ACK delay |
| ack_grant | input | 1 | Transmitter takes the pending ACK request |
| addr_match | output | 1 | One-cycle address-match pulse |
| frame_end | output | 1 | One-cycle end-of-frame pulse |
| crc_valid | output | 1 | CRC verdict of the last reported frame |
| ack_req | output | 1 | ACK transmit request |
| ack_seq | output | 8 | Sequence number to acknowledge |

## Verification
The address decision and the end of the frame can land on the same byte. This happens when the length byte cuts the frame off exactly at the end of its addressing fields. In that case `addr_match` and `frame_end` must pulse together, and the ACK decision must use the match computed on that byte, not a stored one. The bench builds such a frame and a frame shortened by two more bytes. For every byte, the scoreboard compares the pair of pulses against what the frame layout predicts.

// File: rtl/rxf_pkg.sv
// Shared types for the receive filter: addressing modes and the decoded
// frame-control word. Assumes the modes follow the 2-bit field encoding.
package rxf_pkg;

    typedef enum logic [1:0] {
        AM_NONE  = 2'b00,
        AM_RSV   = 2'b01,
        AM_SHORT = 2'b10,
        AM_EXT   = 2'b11
    } addr_mode_e;

    typedef struct packed {
        logic       res_type;   // type field in 3'b100..3'b111
        logic       ack_rq;     // acknowledgement requested
        logic       intra;      // source PAN suppressed
        addr_mode_e dmode;
        addr_mode_e smode;
    } fcf_info_t;

    // Number of address bytes a mode contributes.
    function automatic logic [3:0] mode_len(input addr_mode_e m);
        case (m)
            AM_SHORT: mode_len = 4'd2;
            AM_EXT:   mode_len = 4'd8;
            default:  mode_len = 4'd0;
        endcase
    endfunction

    // Pull the filter-relevant subfields out of a frame-control word.
    function automatic fcf_info_t decode_fcf(input logic [15:0] f);
        fcf_info_t r;
        r.res_type = f[2];
        r.ack_rq   = f[5];
        r.intra    = f[6];
        r.dmode    = addr_mode_e'(f[11:10]);
        r.smode    = addr_mode_e'(f[15:14]);
        return r;
    endfunction

endpackage

// File: rtl/rxf_hdr_parser.sv
// Header walker: tracks the byte position inside a frame, assembles the
// frame-control word, derives the addressing-field layout from it, and
// compares the destination PAN and address byte by byte.
// Assumes the length byte comes with rx_sof and the body bytes follow it,
// low byte first in every multi-byte field.
module rxf_hdr_parser
    import rxf_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic [7:0]       rx_data,
    input  logic [15:0]      cfg_pan_id,
    input  logic [15:0]      cfg_short_addr,
    input  logic [63:0]      cfg_ext_addr,
    output fcf_info_t        info,
    output logic [7:0]       seq,
    output logic             byte_ok,
    output logic             last_byte,
    output logic             hdr_done,
    output logic             pan_eq,
    output logic             pan_bc,
    output logic             adr_eq,
    output logic             adr_bc
);

    localparam logic [LEN_W-1:0] FIXED_LEN = LEN_W'(3);
    localparam logic [LEN_W-1:0] PAN_LEN   = LEN_W'(2);

    logic             in_frame_q;
    logic [LEN_W-1:0] len_q, idx_q;
    logic [15:0]      fcf_q, fcf_n;
    logic [7:0]       seq_q;
    logic             pan_eq_q, pan_bc_q, adr_eq_q, adr_bc_q;

    logic [LEN_W-1:0] dpan_len, dadr_len, span_len, sadr_len, a_dadr, hdr_len;
    logic [LEN_W-1:0] kp_full, ka_full;
    logic             dst_on, in_dpan, in_dadr;
    logic [7:0]       ref_pan, ref_adr;

    // Body-byte strobe and last-byte detection.
    always_comb begin
        byte_ok   = rx_valid & ~rx_sof & in_frame_q;
        last_byte = byte_ok & (idx_q == len_q - 1'b1);
    end

    // Frame-control word including the byte arriving now.
    always_comb begin
        fcf_n = fcf_q;
        if (byte_ok && idx_q == '0)            fcf_n[7:0]  = rx_data;
        if (byte_ok && idx_q == LEN_W'(1))     fcf_n[15:8] = rx_data;
        info = decode_fcf(fcf_n);
        seq  = (byte_ok && idx_q == LEN_W'(2)) ? rx_data : seq_q;
    end

    // Addressing-field layout derived from the modes and intra-PAN flag.
    always_comb begin
        dst_on   = info.dmode[1];
        dpan_len = dst_on ? PAN_LEN : '0;
        dadr_len = LEN_W'(mode_len(info.dmode));
        span_len = (info.smode[1] && !(info.intra && dst_on)) ? PAN_LEN : '0;
        sadr_len = LEN_W'(mode_len(info.smode));
        a_dadr   = FIXED_LEN + dpan_len;
        hdr_len  = a_dadr + dadr_len + span_len + sadr_len;
        hdr_done = byte_ok & (idx_q == hdr_len - 1'b1);
    end

    // Destination comparison for the current byte, folded into running flags.
    always_comb begin
        in_dpan = byte_ok && idx_q >= FIXED_LEN && idx_q < a_dadr;
        in_dadr = byte_ok && idx_q >= a_dadr && idx_q < a_dadr + dadr_len;
        kp_full = idx_q - FIXED_LEN;
        ka_full = idx_q - a_dadr;
        ref_pan = kp_full[0] ? cfg_pan_id[15:8] : cfg_pan_id[7:0];
        if (info.dmode == AM_EXT)
            ref_adr = cfg_ext_addr[{ka_full[2:0], 3'b000} +: 8];
        else
            ref_adr = ka_full[0] ? cfg_short_addr[15:8] : cfg_short_addr[7:0];
        pan_eq = pan_eq_q & (~in_dpan | (rx_data == ref_pan));
        pan_bc = pan_bc_q & (~in_dpan | (rx_data == 8'hFF));
        adr_eq = adr_eq_q & (~in_dadr | (rx_data == ref_adr));
        adr_bc = adr_bc_q & (~in_dadr | (rx_data == 8'hFF));
    end

    // Frame position, header capture and compare-flag state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            len_q      <= '0;
            idx_q      <= '0;
            fcf_q      <= '0;
            seq_q      <= '0;
            pan_eq_q   <= 1'b1;
            pan_bc_q   <= 1'b1;
            adr_eq_q   <= 1'b1;
            adr_bc_q   <= 1'b1;
        end else if (rx_valid && rx_sof) begin
            len_q      <= rx_data[LEN_W-1:0];
            in_frame_q <= |rx_data[LEN_W-1:0];
            idx_q      <= '0;
            fcf_q      <= '0;
            seq_q      <= '0;
            pan_eq_q   <= 1'b1;
            pan_bc_q   <= 1'b1;
            adr_eq_q   <= 1'b1;
            adr_bc_q   <= 1'b1;
        end else if (byte_ok) begin
            idx_q    <= idx_q + 1'b1;
            fcf_q    <= fcf_n;
            seq_q    <= seq;
            pan_eq_q <= pan_eq;
            pan_bc_q <= pan_bc;
            adr_eq_q <= adr_eq;
            adr_bc_q <= adr_bc;
            if (last_byte) in_frame_q <= 1'b0;
        end
    end

endmodule

// File: rtl/rxf_policy.sv
// Filter policy: turns the header walker's compare results into the
// address-match and frame-end pulses, keeps the CRC verdict, and decides
// whether an acknowledgement is due. Assumes the walker's outputs describe
// the byte being accepted in the same cycle.
module rxf_policy
    import rxf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      frame_start,
    input  fcf_info_t info,
    input  logic [7:0] seq_in,
    input  logic      last_byte,
    input  logic      hdr_done,
    input  logic      pan_eq,
    input  logic      pan_bc,
    input  logic      adr_eq,
    input  logic      adr_bc,
    input  logic      crc_in,
    input  logic      cfg_promisc,
    input  logic      cfg_res_upload,
    input  logic      cfg_res_filter,
    output logic      addr_match,
    output logic      frame_end,
    output logic      crc_valid,
    output logic      ack_launch,
    output logic [7:0] launch_seq
);

    logic match_q;
    logic res_bypass, drop, pan_ok, dst_ok, match_now, match_final, end_now, launch_now;

    // Decision logic for the byte being accepted.
    always_comb begin
        res_bypass  = info.res_type & ~cfg_res_filter & ~cfg_promisc;
        drop        = res_bypass & ~cfg_res_upload;
        pan_ok      = pan_eq | pan_bc;
        dst_ok      = ((info.dmode == AM_SHORT) & pan_ok & (adr_eq | adr_bc)) |
                      ((info.dmode == AM_EXT)   & pan_ok & adr_eq);
        match_now   = hdr_done & (cfg_promisc | (~res_bypass & dst_ok));
        match_final = hdr_done ? match_now : match_q;
        end_now     = last_byte & ~drop;
        launch_now  = end_now & match_final & ~cfg_promisc & crc_in & info.ack_rq;
    end

    // Registered event pulses, CRC verdict and ACK launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q    <= 1'b0;
            addr_match <= 1'b0;
            frame_end  <= 1'b0;
            crc_valid  <= 1'b0;
            ack_launch <= 1'b0;
            launch_seq <= '0;
        end else begin
            addr_match <= match_now;
            frame_end  <= end_now;
            ack_launch <= launch_now;
            if (frame_start)   match_q    <= 1'b0;
            else if (hdr_done) match_q    <= match_now;
            if (end_now)       crc_valid  <= crc_in;
            if (launch_now)    launch_seq <= seq_in;
        end
    end

endmodule

// File: rtl/rxf_ack_sched.sv
// ACK scheduler: after a launch it counts symbol ticks for the slow or
// fast turnaround and then holds a request with the sequence number until
// it is granted. Assumes sym_tick is a single-cycle pulse. Launches that
// arrive while a request is counting or pending are ignored.
module rxf_ack_sched #(
    parameter int SYM_TICKS = 16,
    parameter int SLOW_SYMS = 12,
    parameter int FAST_SYMS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  logic [7:0] launch_seq,
    input  logic       fast,
    input  logic       sym_tick,
    input  logic       ack_grant,
    output logic       ack_req,
    output logic [7:0] ack_seq
);

    localparam int SLOW_T = SLOW_SYMS * SYM_TICKS;
    localparam int FAST_T = FAST_SYMS * SYM_TICKS;
    localparam int CNT_W  = $clog2(SLOW_T + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    // Delay counter and request handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            ack_req <= 1'b0;
            ack_seq <= '0;
        end else begin
            if (launch && !busy_q && !ack_req) begin
                busy_q  <= 1'b1;
                cnt_q   <= fast ? CNT_W'(FAST_T) : CNT_W'(SLOW_T);
                ack_seq <= launch_seq;
            end else if (busy_q && sym_tick) begin
                if (cnt_q == CNT_W'(1)) begin
                    busy_q  <= 1'b0;
                    ack_req <= 1'b1;
                end
                cnt_q <= cnt_q - 1'b1;
            end
            if (ack_req && ack_grant) ack_req <= 1'b0;
        end
    end

endmodule

// File: rtl/rx_frame_filter.sv
// Top of the receive address filter: wires the header walker, the filter
// policy and the ACK scheduler. Assumes one receive byte per cycle at most
// and configuration held steady while a frame is in flight.
module rx_frame_filter #(
    parameter int LEN_W     = 7,
    parameter int SYM_TICKS = 16,
    parameter int SLOW_SYMS = 12,
    parameter int FAST_SYMS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic [7:0]  rx_data,
    input  logic        rx_crc_ok,
    input  logic        sym_tick,
    input  logic [15:0] cfg_pan_id,
    input  logic [15:0] cfg_short_addr,
    input  logic [63:0] cfg_ext_addr,
    input  logic        cfg_promisc,
    input  logic        cfg_res_upload,
    input  logic        cfg_res_filter,
    input  logic        cfg_fast_ack,
    input  logic        ack_grant,
    output logic        addr_match,
    output logic        frame_end,
    output logic        crc_valid,
    output logic        ack_req,
    output logic [7:0]  ack_seq
);

    rxf_pkg::fcf_info_t info;
    logic [7:0] seq, launch_seq;
    logic byte_ok, last_byte, hdr_done, pan_eq, pan_bc, adr_eq, adr_bc, ack_launch;

    rxf_hdr_parser #(.LEN_W(LEN_W)) u_parse (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_data(rx_data), .cfg_pan_id(cfg_pan_id), .cfg_short_addr(cfg_short_addr),
        .cfg_ext_addr(cfg_ext_addr), .info(info), .seq(seq), .byte_ok(byte_ok),
        .last_byte(last_byte), .hdr_done(hdr_done), .pan_eq(pan_eq),
        .pan_bc(pan_bc), .adr_eq(adr_eq), .adr_bc(adr_bc)
    );

    rxf_policy u_policy (
        .clk(clk), .rst_n(rst_n), .frame_start(rx_valid & rx_sof), .info(info),
        .seq_in(seq), .last_byte(last_byte), .hdr_done(hdr_done),
        .pan_eq(pan_eq), .pan_bc(pan_bc), .adr_eq(adr_eq), .adr_bc(adr_bc),
        .crc_in(rx_crc_ok), .cfg_promisc(cfg_promisc),
        .cfg_res_upload(cfg_res_upload), .cfg_res_filter(cfg_res_filter),
        .addr_match(addr_match), .frame_end(frame_end), .crc_valid(crc_valid),
        .ack_launch(ack_launch), .launch_seq(launch_seq)
    );

    rxf_ack_sched #(
        .SYM_TICKS(SYM_TICKS), .SLOW_SYMS(SLOW_SYMS), .FAST_SYMS(FAST_SYMS)
    ) u_ack (
        .clk(clk), .rst_n(rst_n), .launch(ack_launch), .launch_seq(launch_seq),
        .fast(cfg_fast_ack), .sym_tick(sym_tick), .ack_grant(ack_grant),
        .ack_req(ack_req), .ack_seq(ack_seq)
    );

endmodule

// File: rtl/rxf_checker.sv
// Property checker for the receive filter, attached to the top by bind.
// Assumes the same clock and synchronous active-low reset as the design.
module rxf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_sof,
    input logic [7:0] rx_data,
    input logic       addr_match,
    input logic       frame_end,
    input logic       crc_valid,
    input logic       ack_req,
    input logic       ack_grant,
    input logic [7:0] ack_seq
);

    // R2: an empty length byte produces no event on the next cycle.
    a_r2_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_sof && ((rx_data & 8'h7F) == 8'h00)) |=> (!addr_match && !frame_end));

    // R3: the address-match event is a single-cycle pulse.
    a_r3_match_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match |=> !addr_match);

    // R10: the CRC verdict changes only together with a frame-end pulse.
    a_r10_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |-> $stable(crc_valid));

    // R11: an ungranted request stays up with a steady sequence number.
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !ack_grant) |=> (ack_req && $stable(ack_seq)));

    // R11: a granted request is withdrawn.
    a_r11_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && ack_grant) |=> !ack_req);

endmodule

bind rx_frame_filter rxf_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_data(rx_data), .addr_match(addr_match), .frame_end(frame_end),
    .crc_valid(crc_valid), .ack_req(ack_req), .ack_grant(ack_grant),
    .ack_seq(ack_seq)
);

// File: tb/rx_frame_filter_tb.sv
`timescale 1ns/1ps
module rx_frame_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_crc_ok = 1'b0, sym_tick = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [15:0] cfg_pan_id = 16'h1234, cfg_short_addr = 16'hBEEF;
    logic [63:0] cfg_ext_addr = 64'h0011_2233_4455_6677;
    logic        cfg_promisc = 0, cfg_res_upload = 0, cfg_res_filter = 0, cfg_fast_ack = 0;
    logic        ack_grant = 1'b0;
    logic        addr_match, frame_end, crc_valid, ack_req;
    logic [7:0]  ack_seq;

    int errs = 0, checks = 0;
    string cur_req = "R1";
    logic [2:0] exp_q[$];
    logic [2:0] e;
    logic sent_q = 1'b0;
    logic [7:0] fb [0:127];
    int fn, hl;

    always #2 clk = ~clk;

    rx_frame_filter u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_data(rx_data), .rx_crc_ok(rx_crc_ok), .sym_tick(sym_tick),
        .cfg_pan_id(cfg_pan_id), .cfg_short_addr(cfg_short_addr),
        .cfg_ext_addr(cfg_ext_addr), .cfg_promisc(cfg_promisc),
        .cfg_res_upload(cfg_res_upload), .cfg_res_filter(cfg_res_filter),
        .cfg_fast_ack(cfg_fast_ack), .ack_grant(ack_grant),
        .addr_match(addr_match), .frame_end(frame_end), .crc_valid(crc_valid),
        .ack_req(ack_req), .ack_seq(ack_seq)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Marks the cycles in which the design accepted a byte.
    always @(posedge clk) sent_q <= rx_valid;

    // Monitor: compares the event pulses after each accepted byte with the scoreboard.
    always @(negedge clk) begin
        if (sent_q) begin
            checks++;
            if (exp_q.size() == 0) begin
                errs++;
                $display("FAIL %s: actual=scoreboard-empty expected=entry", cur_req);
            end else begin
                e = exp_q.pop_front();
                if (addr_match !== e[2] || frame_end !== e[1] || (e[1] && crc_valid !== e[0])) begin
                    errs++;
                    $display("FAIL %s: actual=%b%b%b expected=%b", cur_req,
                             addr_match, frame_end, crc_valid, e);
                end
            end
        end else if (rst_n && (addr_match || frame_end)) begin
            checks++;
            errs++;
            $display("FAIL %s: actual=%b%b expected=00 (spurious event)", cur_req, addr_match, frame_end);
        end
    end

    // Driver: pushes the expected {match,end,crc} and presents one byte.
    task automatic push_byte(input logic [7:0] d, input logic sof, input logic crc, input logic [2:0] ex);
        exp_q.push_back(ex);
        rx_valid = 1'b1; rx_sof = sof; rx_data = d; rx_crc_ok = crc;
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0;
    endtask

    // Sends fb[0..fn-1] with its length byte; match_at is the body index (or -1).
    task automatic send_frame(input int match_at, input bit exp_end, input bit crc);
        push_byte(8'(fn), 1'b1, crc, 3'b000);
        for (int i = 0; i < fn; i++)
            push_byte(fb[i], 1'b0, crc, {(i == match_at), (exp_end && i == fn - 1), crc});
        repeat (2) @(negedge clk);
    endtask

    // Builds a frame body; hl receives the byte count up to the end of the addressing fields.
    task automatic mk(input logic [2:0] ft, input bit ackb, input bit intra,
                      input logic [1:0] dm, input logic [1:0] sm, input logic [7:0] sq,
                      input logic [15:0] dpan, input logic [63:0] dadr,
                      input logic [15:0] span, input logic [63:0] sadr, input int pay);
        logic [15:0] f;
        f = {sm, 2'b00, dm, 3'b000, intra, ackb, 2'b00, ft};
        fn = 0;
        fb[fn++] = f[7:0]; fb[fn++] = f[15:8]; fb[fn++] = sq;
        if (dm[1]) begin
            fb[fn++] = dpan[7:0]; fb[fn++] = dpan[15:8];
            for (int k = 0; k < (dm == 2'b11 ? 8 : 2); k++) fb[fn++] = dadr[8*k +: 8];
        end
        if (sm[1] && !(intra && dm[1])) begin
            fb[fn++] = span[7:0]; fb[fn++] = span[15:8];
        end
        if (sm[1])
            for (int k = 0; k < (sm == 2'b11 ? 8 : 2); k++) fb[fn++] = sadr[8*k +: 8];
        hl = fn;
        for (int k = 0; k < pay; k++) fb[fn++] = 8'hA0 + 8'(k);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            sym_tick = 1'b1; @(negedge clk);
            sym_tick = 1'b0; @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL R11: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({addr_match, frame_end, crc_valid, ack_req} == 4'b0, "R1 in reset", {addr_match, frame_end, crc_valid, ack_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({addr_match, frame_end, crc_valid, ack_req} == 4'b0, "R1 after reset", {addr_match, frame_end, crc_valid, ack_req}, 0);

        // R3: short destination match, no intra-PAN, crc good
        cur_req = "R3";
        mk(3'd1, 0, 0, 2'b10, 2'b10, 8'h11, 16'h1234, 64'hBEEF, 16'h1234, 64'h0042, 3);
        send_frame(hl - 1, 1, 1);

        // R6: intra-PAN drops the source PAN, addressing ends two bytes earlier
        cur_req = "R6";
        mk(3'd1, 0, 1, 2'b10, 2'b10, 8'h12, 16'h1234, 64'hBEEF, 16'h0000, 64'h0042, 3);
        chk(hl == 9, "R6 layout", hl, 9);
        send_frame(hl - 1, 1, 1);

        // R4: broadcast PAN and short address accepted
        cur_req = "R4";
        mk(3'd1, 0, 0, 2'b10, 2'b00, 8'h13, 16'hFFFF, 64'hFFFF, 0, 0, 2);
        send_frame(hl - 1, 1, 0);
        // R4/R13: mismatching short address with ACK bit: frame_end only, no ACK
        mk(3'd1, 1, 0, 2'b10, 2'b00, 8'h14, 16'h1234, 64'hBEEE, 0, 0, 2);
        send_frame(-1, 1, 1);
        ticks(200);
        chk(ack_req == 1'b0, "R13 unmatched no ack", ack_req, 0);

        // R5: extended destination match and all-ones mismatch
        cur_req = "R5";
        mk(3'd3, 0, 0, 2'b11, 2'b00, 8'h15, 16'h1234, 64'h0011_2233_4455_6677, 0, 0, 2);
        send_frame(hl - 1, 1, 1);
        mk(3'd1, 0, 0, 2'b11, 2'b00, 8'h16, 16'h1234, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 2);
        send_frame(-1, 1, 1);

        // R14: addressing ends on the last byte, then a frame cut short
        cur_req = "R14";
        mk(3'd1, 0, 0, 2'b10, 2'b00, 8'h17, 16'h1234, 64'hBEEF, 0, 0, 0);
        send_frame(hl - 1, 1, 1);
        fn = hl - 2;
        send_frame(-1, 1, 0);

        // R10: crc_valid holds across an empty length byte
        cur_req = "R10";
        chk(crc_valid == 1'b0, "R10 latched bad crc", crc_valid, 0);
        mk(3'd1, 0, 0, 2'b10, 2'b00, 8'h18, 16'h1234, 64'hBEEF, 0, 0, 2);
        send_frame(hl - 1, 1, 1);
        cur_req = "R2";
        fn = 0;
        send_frame(-1, 0, 0);
        chk(crc_valid == 1'b1, "R10 held after empty frame", crc_valid, 1);

        // R7: reserved type, upload on, filter off: frame_end only
        cur_req = "R7";
        cfg_res_upload = 1;
        mk(3'd5, 0, 0, 2'b10, 2'b00, 8'h19, 16'h1234, 64'hBEEF, 0, 0, 2);
        send_frame(-1, 1, 1);
        cfg_res_upload = 0;
        send_frame(-1, 0, 1);

        // R8: reserved type filtered like data
        cur_req = "R8";
        cfg_res_filter = 1;
        mk(3'd4, 0, 0, 2'b10, 2'b00, 8'h1A, 16'h1234, 64'hBEEF, 0, 0, 2);
        send_frame(hl - 1, 1, 1);
        mk(3'd4, 0, 0, 2'b10, 2'b00, 8'h1B, 16'h4321, 64'hBEEF, 0, 0, 2);
        send_frame(-1, 1, 1);
        cfg_res_filter = 0;

        // R9: promiscuous reports a foreign frame and never acknowledges
        cur_req = "R9";
        cfg_promisc = 1;
        mk(3'd1, 1, 0, 2'b10, 2'b10, 8'h1C, 16'h5555, 64'h6666, 16'h7777, 64'h8888, 2);
        send_frame(hl - 1, 1, 1);
        ticks(200);
        chk(ack_req == 1'b0, "R9 no ack in promiscuous", ack_req, 0);
        cfg_promisc = 0;

        // R13: bad CRC, and ACK bit clear, give no request
        cur_req = "R13";
        mk(3'd1, 1, 0, 2'b10, 2'b00, 8'h1D, 16'h1234, 64'hBEEF, 0, 0, 2);
        send_frame(hl - 1, 1, 0);
        ticks(200);
        chk(ack_req == 1'b0, "R13 bad crc", ack_req, 0);
        mk(3'd1, 0, 0, 2'b10, 2'b00, 8'h1E, 16'h1234, 64'hBEEF, 0, 0, 2);
        send_frame(hl - 1, 1, 1);
        ticks(200);
        chk(ack_req == 1'b0, "R13 ack bit clear", ack_req, 0);

        // R11: slow turnaround of 192 ticks
        cur_req = "R11";
        mk(3'd1, 1, 0, 2'b10, 2'b10, 8'h5A, 16'h1234, 64'hBEEF, 16'h1234, 64'h0042, 2);
        send_frame(hl - 1, 1, 1);
        chk(ack_req == 1'b0, "R11 idle before ticks", ack_req, 0);
        ticks(191);
        chk(ack_req == 1'b0, "R11 not before tick 192", ack_req, 0);
        ticks(1);
        chk(ack_req == 1'b1, "R11 raised at tick 192", ack_req, 1);
        chk(ack_seq == 8'h5A, "R11 sequence", ack_seq, 8'h5A);
        repeat (3) @(negedge clk);
        chk(ack_req == 1'b1, "R11 held without grant", ack_req, 1);
        ack_grant = 1; @(negedge clk); ack_grant = 0;
        chk(ack_req == 1'b0, "R11 released by grant", ack_req, 0);

        // R12: fast turnaround of 32 ticks
        cur_req = "R12";
        cfg_fast_ack = 1;
        mk(3'd1, 1, 1, 2'b10, 2'b10, 8'hC3, 16'h1234, 64'hFFFF, 16'h0000, 64'h0042, 2);
        send_frame(hl - 1, 1, 1);
        ticks(31);
        chk(ack_req == 1'b0, "R12 not before tick 32", ack_req, 0);
        ticks(1);
        chk(ack_req == 1'b1, "R12 raised at tick 32", ack_req, 1);
        chk(ack_seq == 8'hC3, "R12 sequence", ack_seq, 8'hC3);
        ack_grant = 1; @(negedge clk); ack_grant = 0;

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule